// File: doc/BRIEF.md
# Banked Working-Register RAM with Upward Stack

This block holds the 128-byte internal scratch memory of a small 8-bit controller core. It has three ways in. The first is a working-register port: a register number from 0 to 7 is combined with a 2-bit bank number and becomes a low RAM address. The second is a plain direct-address port that reaches every byte. The third is a hardware stack kept by an 8-bit pointer that software may reload at any time.

The pointer always names the most recently filled stack slot. A push moves the pointer up first and then stores the byte. A pop returns the byte under the pointer and then moves the pointer down. Because the pointer leaves reset at 07H, the first pushed byte shares storage with register 0 of bank 1. A program that needs that bank moves the stack by loading the pointer, for example to 60H. Stack slots from 80H upward have no storage behind them and are flagged. When two writes contend for the single write port in the same cycle, a fixed priority picks one, and a busy output tells the requester which write to hold.

Top module: `iram_bank_stack`

## Requirements
- R1: Each of the 128 bytes (addresses 00H-7FH) can be written and read through the direct port. Read data appears on `dir_rd_data` one clock edge after the address is presented.
- R2: The register port reaches address 8*bank + reg, where bank = {`bank_sel[1]`,`bank_sel[0]`} with bit 1 as the high bit. Data written there is seen on the direct port, and register read data appears one edge after the request.
- R3: While reset is held and after reset, `sp_out` is 07H and `stk_ovf` and `wr_busy` are 0.
- R4: A push adds one to the pointer and stores `stk_wr_data` at the new pointer value. The new pointer is visible one edge later.
- R5: A pop drives the byte at the current pointer onto `pop_data` one edge later and subtracts one from the pointer. `pop_data` holds its value until the next pop.
- R6: `sp_load_en` loads `sp_load_val` into the pointer. A push or pop requested in the same cycle is ignored: nothing is written to RAM and `pop_data` is unchanged.
- R7: A push whose new pointer is 80H or more writes no RAM byte and raises `stk_ovf` for exactly one cycle. A pop at a pointer of 80H or more returns 00H. The pointer updates in both cases.
- R8: The pointer wraps modulo 256: a push at FFH gives 00H and stores at address 00H, and a pop at 00H gives FFH.
- R9: The write port grants push first, then register write, then direct write. `wr_busy` is asserted combinationally in the same cycle whenever a requested register or direct write is not granted, and that write has no effect.
- R10: A read and a write to the same address in the same cycle on the register port or the direct port return the old byte.
- R11: A push and a pop requested together perform only the push. `pop_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_sel | input | 2 | Active register bank |
| reg_num | input | 3 | Working register number |
| reg_wr_en | input | 1 | Register write request |
| reg_wr_data | input | 8 | Register write byte |
| reg_rd_data | output | 8 | Registered read of the addressed working register |
| dir_addr | input | 7 | Direct address |
| dir_wr_en | input | 1 | Direct write request |
| dir_wr_data | input | 8 | Direct write byte |
| dir_rd_data | output | 8 | Registered read of the direct address |
| push_req | input | 1 | Push strobe |
| pop_req | input | 1 | Pop strobe |
| stk_wr_data | input | 8 | Byte to push |
| pop_data | output | 8 | Last popped byte |
| sp_load_en | input | 1 | Pointer load strobe |
| sp_load_val | input | 8 | Pointer load value |
| sp_out | output | 8 | Current stack pointer |
| stk_ovf | output | 1 | One-cycle flag: a push landed beyond the storage |
| wr_busy | output | 1 | A requested register or direct write was not granted this cycle |

## Verification
The only combinational result is `wr_busy`. The bench reads it one time step after driving the colliding requests and before the clock edge. Every other result passes through one register and is sampled at the falling edge that follows the rising edge on which the request was taken. `stk_ovf` is also checked one cycle later, to show it has dropped again. Rejected writes (blocked by priority, by a pointer load, or beyond 7FH) are confirmed by reading the affected addresses back through the direct port. Aliasing address 00H is included in these read-backs.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_INC  = 2'd1,
    SP_DEC  = 2'd2,
    SP_LOAD = 2'd3
  } sp_op_e;

  typedef enum logic [1:0] {
    WSRC_NONE = 2'd0,
    WSRC_PUSH = 2'd1,
    WSRC_REG  = 2'd2,
    WSRC_DIR  = 2'd3
  } wsrc_e;
endpackage

// File: rtl/iram_rst_sync.sv
module iram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/iram_addr_map.sv
module iram_addr_map #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned RN_W   = 3,
  parameter int unsigned ADDR_W = 7
) (
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [RN_W-1:0]   reg_num,
  output logic [ADDR_W-1:0] reg_addr
);
  localparam int unsigned PAD = ADDR_W - BANK_W - RN_W;

  // bank number forms the upper bits, so address = bank*2^RN_W + reg
  generate
    if (PAD > 0) begin : g_pad
      assign reg_addr = {{PAD{1'b0}}, bank_sel, reg_num};
    end else begin : g_nopad
      assign reg_addr = {bank_sel, reg_num};
    end
  endgenerate
endmodule

// File: rtl/iram_sp_unit.sv
module iram_sp_unit
  import iram_pkg::*;
#(
  parameter int unsigned SP_W     = 8,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned SP_RESET = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic              load_en,
  input  logic [SP_W-1:0]   load_val,
  output logic [SP_W-1:0]   sp_q,
  output sp_op_e            op,
  output logic [ADDR_W-1:0] push_addr,
  output logic              push_ok,
  output logic [ADDR_W-1:0] pop_addr,
  output logic              pop_ok,
  output logic              ovf_q
);
  logic [SP_W-1:0] sp_inc, sp_dec, sp_d;
  logic            sp_en, ovf_d;

  always_comb begin
    sp_inc = sp_q + SP_W'(1);
    sp_dec = sp_q - SP_W'(1);

    if (load_en)       op = SP_LOAD;
    else if (push_req) op = SP_INC;
    else if (pop_req)  op = SP_DEC;
    else               op = SP_HOLD;

    case (op)
      SP_INC:  sp_d = sp_inc;
      SP_DEC:  sp_d = sp_dec;
      SP_LOAD: sp_d = load_val;
      default: sp_d = sp_q;
    endcase
    sp_en = (op != SP_HOLD);

    push_addr = sp_inc[ADDR_W-1:0];
    push_ok   = ~|sp_inc[SP_W-1:ADDR_W];
    pop_addr  = sp_q[ADDR_W-1:0];
    pop_ok    = ~|sp_q[SP_W-1:ADDR_W];
    ovf_d     = (op == SP_INC) && !push_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= SP_W'(SP_RESET);
      ovf_q <= 1'b0;
    end else begin
      if (sp_en) sp_q <= sp_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/iram_wr_arb.sv
module iram_wr_arb
  import iram_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              push_act,
  input  logic              push_ok,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_data,
  input  logic              dir_wr_en,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [DATA_W-1:0] dir_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);
  wsrc_e src;

  always_comb begin
    if (push_act)       src = WSRC_PUSH;
    else if (reg_wr_en) src = WSRC_REG;
    else if (dir_wr_en) src = WSRC_DIR;
    else                src = WSRC_NONE;

    mem_we    = 1'b0;
    mem_waddr = dir_addr;
    mem_wdata = dir_data;
    case (src)
      WSRC_PUSH: begin
        mem_we    = push_ok;
        mem_waddr = push_addr;
        mem_wdata = push_data;
      end
      WSRC_REG: begin
        mem_we    = 1'b1;
        mem_waddr = reg_addr;
        mem_wdata = reg_data;
      end
      WSRC_DIR: mem_we = 1'b1;
      default:  mem_we = 1'b0;
    endcase

    busy = (reg_wr_en && (src != WSRC_REG)) || (dir_wr_en && (src != WSRC_DIR));
  end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  input  logic [ADDR_W-1:0] dir_raddr,
  input  logic              pop_act,
  input  logic              pop_ok,
  input  logic [ADDR_W-1:0] pop_raddr,
  output logic [DATA_W-1:0] reg_rd_q,
  output logic [DATA_W-1:0] dir_rd_q,
  output logic [DATA_W-1:0] pop_q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] pop_d;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    pop_d = pop_ok ? mem[pop_raddr] : '0;
  end

  // read registers sample the array before this edge's write lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rd_q <= '0;
      dir_rd_q <= '0;
      pop_q    <= '0;
    end else begin
      reg_rd_q <= mem[reg_raddr];
      dir_rd_q <= mem[dir_raddr];
      if (pop_act) pop_q <= pop_d;
    end
  end
endmodule

// File: rtl/iram_bank_stack.sv
module iram_bank_stack
  import iram_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned BANKS    = 4,
  parameter int unsigned REGS     = 8,
  parameter int unsigned SP_W     = 8,
  parameter int unsigned SP_RESET = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(BANKS)-1:0] bank_sel,
  input  logic [$clog2(REGS)-1:0]  reg_num,
  input  logic                     reg_wr_en,
  input  logic [DATA_W-1:0]        reg_wr_data,
  output logic [DATA_W-1:0]        reg_rd_data,
  input  logic [ADDR_W-1:0]        dir_addr,
  input  logic                     dir_wr_en,
  input  logic [DATA_W-1:0]        dir_wr_data,
  output logic [DATA_W-1:0]        dir_rd_data,
  input  logic                     push_req,
  input  logic                     pop_req,
  input  logic [DATA_W-1:0]        stk_wr_data,
  output logic [DATA_W-1:0]        pop_data,
  input  logic                     sp_load_en,
  input  logic [SP_W-1:0]          sp_load_val,
  output logic [SP_W-1:0]          sp_out,
  output logic                     stk_ovf,
  output logic                     wr_busy
);
  localparam int unsigned BANK_W = $clog2(BANKS);
  localparam int unsigned RN_W   = $clog2(REGS);

  logic              rst_sync_n;
  logic [ADDR_W-1:0] reg_addr;
  sp_op_e            sp_op;
  logic [ADDR_W-1:0] push_addr, pop_addr;
  logic              push_ok, pop_ok, push_act, pop_act;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  iram_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  iram_addr_map #(.BANK_W(BANK_W), .RN_W(RN_W), .ADDR_W(ADDR_W)) map_i (
    .bank_sel(bank_sel), .reg_num(reg_num), .reg_addr(reg_addr)
  );

  iram_sp_unit #(.SP_W(SP_W), .ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) sp_i (
    .clk(clk), .rst_n(rst_sync_n),
    .push_req(push_req), .pop_req(pop_req),
    .load_en(sp_load_en), .load_val(sp_load_val),
    .sp_q(sp_out), .op(sp_op),
    .push_addr(push_addr), .push_ok(push_ok),
    .pop_addr(pop_addr), .pop_ok(pop_ok),
    .ovf_q(stk_ovf)
  );

  assign push_act = (sp_op == SP_INC);
  assign pop_act  = (sp_op == SP_DEC);

  iram_wr_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arb_i (
    .push_act(push_act), .push_ok(push_ok),
    .push_addr(push_addr), .push_data(stk_wr_data),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_data(reg_wr_data),
    .dir_wr_en(dir_wr_en), .dir_addr(dir_addr), .dir_data(dir_wr_data),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .busy(wr_busy)
  );

  iram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_sync_n),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .reg_raddr(reg_addr), .dir_raddr(dir_addr),
    .pop_act(pop_act), .pop_ok(pop_ok), .pop_raddr(pop_addr),
    .reg_rd_q(reg_rd_data), .dir_rd_q(dir_rd_data), .pop_q(pop_data)
  );
endmodule

// File: rtl/iram_bank_stack_chk.sv
module iram_bank_stack_chk #(
  parameter int unsigned SP_W   = 8,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_req,
  input logic              pop_req,
  input logic              sp_load_en,
  input logic [SP_W-1:0]   sp_load_val,
  input logic [SP_W-1:0]   sp_out,
  input logic              stk_ovf,
  input logic [DATA_W-1:0] pop_data,
  input logic              wr_busy,
  input logic              reg_wr_en,
  input logic              dir_wr_en
);
  localparam logic [SP_W-1:0] LAST_SLOT = SP_W'((1 << ADDR_W) - 1);
  localparam logic [SP_W-1:0] FIRST_OOB = SP_W'(1 << ADDR_W);

  assert_push_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !sp_load_en) |=> (sp_out == $past(sp_out) + SP_W'(1)));

  assert_pop_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !sp_load_en) |=> (sp_out == $past(sp_out) - SP_W'(1)));

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load_en |=> (sp_out == $past(sp_load_val)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_req && !pop_req && !sp_load_en) |=> $stable(sp_out));

  assert_ovf_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !sp_load_en && sp_out >= LAST_SLOT && sp_out != '1) |=> stk_ovf);

  assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |-> $past(push_req));

  assert_pop_oob_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !sp_load_en && sp_out >= FIRST_OOB) |=> (pop_data == '0));

  assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> (reg_wr_en || dir_wr_en));

  assert_busy_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !sp_load_en && dir_wr_en) |-> wr_busy);
endmodule

bind iram_bank_stack iram_bank_stack_chk #(
  .SP_W(SP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_sync_n),
  .push_req(push_req), .pop_req(pop_req),
  .sp_load_en(sp_load_en), .sp_load_val(sp_load_val),
  .sp_out(sp_out), .stk_ovf(stk_ovf), .pop_data(pop_data),
  .wr_busy(wr_busy), .reg_wr_en(reg_wr_en), .dir_wr_en(dir_wr_en)
);

// File: tb/iram_bank_stack_tb.sv
module iram_bank_stack_tb_top;
  logic       clk;
  logic       rst_n;
  logic [1:0] bank_sel;
  logic [2:0] reg_num;
  logic       reg_wr_en;
  logic [7:0] reg_wr_data, reg_rd_data;
  logic [6:0] dir_addr;
  logic       dir_wr_en;
  logic [7:0] dir_wr_data, dir_rd_data;
  logic       push_req, pop_req;
  logic [7:0] stk_wr_data, pop_data;
  logic       sp_load_en;
  logic [7:0] sp_load_val, sp_out;
  logic       stk_ovf, wr_busy;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  logic [7:0] exp_mem [128];
  logic [7:0] exp_sp;
  logic [7:0] last_pop;

  iram_bank_stack dut_i (
    .clk(clk), .rst_n(rst_n),
    .bank_sel(bank_sel), .reg_num(reg_num),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .dir_addr(dir_addr), .dir_wr_en(dir_wr_en), .dir_wr_data(dir_wr_data),
    .dir_rd_data(dir_rd_data),
    .push_req(push_req), .pop_req(pop_req), .stk_wr_data(stk_wr_data),
    .pop_data(pop_data),
    .sp_load_en(sp_load_en), .sp_load_val(sp_load_val), .sp_out(sp_out),
    .stk_ovf(stk_ovf), .wr_busy(wr_busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic dwrite(input logic [6:0] a, input logic [7:0] d);
    dir_addr = a; dir_wr_data = d; dir_wr_en = 1'b1;
    cyc();
    dir_wr_en = 1'b0;
    exp_mem[a] = d;
  endtask

  task automatic dcheck(input string req, input logic [6:0] a);
    dir_addr = a;
    cyc();
    check(req, dir_rd_data, exp_mem[a]);
  endtask

  task automatic do_push(input string req, input logic [7:0] d);
    push_req = 1'b1; stk_wr_data = d;
    cyc();
    push_req = 1'b0;
    exp_sp = exp_sp + 8'd1;
    if (exp_sp < 8'h80) exp_mem[exp_sp[6:0]] = d;
    check(req, sp_out, exp_sp);
    check(req, {7'd0, stk_ovf}, {7'd0, exp_sp >= 8'h80});
  endtask

  task automatic do_pop(input string req);
    logic [7:0] e;
    e = (exp_sp < 8'h80) ? exp_mem[exp_sp[6:0]] : 8'h00;
    pop_req = 1'b1;
    cyc();
    pop_req = 1'b0;
    exp_sp = exp_sp - 8'd1;
    last_pop = e;
    check(req, pop_data, e);
    check(req, sp_out, exp_sp);
  endtask

  task automatic do_load(input logic [7:0] v);
    sp_load_en = 1'b1; sp_load_val = v;
    cyc();
    sp_load_en = 1'b0;
    exp_sp = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bank_sel = '0; reg_num = '0; reg_wr_en = 1'b0; reg_wr_data = '0;
    dir_addr = '0; dir_wr_en = 1'b0; dir_wr_data = '0; push_req = 1'b0; pop_req = 1'b0;
    stk_wr_data = '0; sp_load_en = 1'b0; sp_load_val = '0;
    repeat (3) @(negedge clk);
    check("R3 sp in reset", sp_out, 8'h07);
    check("R3 ovf in reset", {7'd0, stk_ovf}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 sp after reset", sp_out, 8'h07);
    check("R3 ovf after reset", {7'd0, stk_ovf}, 8'h00);
    check("R3 busy after reset", {7'd0, wr_busy}, 8'h00);
    exp_sp = 8'h07;
    last_pop = 8'h00;

    // R1: full direct sweep
    for (int a = 0; a < 128; a++) dwrite(7'(a), 8'(a * 3) ^ 8'hA5);
    for (int a = 0; a < 128; a++) dcheck("R1 direct readback", 7'(a));

    // R2: every bank and register
    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 8; n++) begin
        bank_sel = 2'(b); reg_num = 3'(n);
        reg_wr_data = 8'(8'h40 + b * 8 + n); reg_wr_en = 1'b1;
        cyc();
        reg_wr_en = 1'b0;
        exp_mem[b * 8 + n] = 8'(8'h40 + b * 8 + n);
      end
    end
    for (int a = 0; a < 128; a++) dcheck("R2 mapped address", 7'(a));
    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 8; n++) begin
        bank_sel = 2'(b); reg_num = 3'(n);
        cyc();
        check("R2 register readback", reg_rd_data, 8'(8'h40 + b * 8 + n));
      end
    end

    // R4 / R5: default stack overlaps bank 1
    do_push("R4 push", 8'h11);
    do_push("R4 push", 8'h22);
    do_push("R4 push", 8'h33);
    dcheck("R4 stored at 08", 7'h08);
    dcheck("R4 stored at 0A", 7'h0A);
    bank_sel = 2'd1; reg_num = 3'd0;
    cyc();
    check("R4 bank1 r0 sees push", reg_rd_data, 8'h11);
    do_pop("R5 pop");
    do_pop("R5 pop");
    do_pop("R5 pop");
    cyc();
    check("R5 pop_data held", pop_data, last_pop);

    // R6: relocate and load priority
    do_load(8'h60);
    check("R6 load value", sp_out, 8'h60);
    do_push("R6 relocated push", 8'h77);
    dcheck("R6 stored at 61", 7'h61);
    sp_load_en = 1'b1; sp_load_val = 8'h40; push_req = 1'b1; stk_wr_data = 8'hF0;
    cyc();
    sp_load_en = 1'b0; push_req = 1'b0; exp_sp = 8'h40;
    check("R6 load beats push", sp_out, 8'h40);
    dcheck("R6 ignored push wrote nothing", 7'h41);
    dcheck("R6 ignored push wrote nothing", 7'h62);
    sp_load_en = 1'b1; sp_load_val = 8'h30; pop_req = 1'b1;
    cyc();
    sp_load_en = 1'b0; pop_req = 1'b0; exp_sp = 8'h30;
    check("R6 load beats pop sp", sp_out, 8'h30);
    check("R6 load beats pop data", pop_data, last_pop);

    // R7: edge of storage
    do_load(8'h7E);
    do_push("R7 last slot", 8'hAA);
    do_push("R7 beyond storage", 8'hBB);
    cyc();
    check("R7 ovf one cycle", {7'd0, stk_ovf}, 8'h00);
    dcheck("R7 no alias at 00", 7'h00);
    dcheck("R7 7F intact", 7'h7F);
    do_push("R7 beyond storage", 8'hCC);
    dcheck("R7 no alias at 01", 7'h01);
    do_pop("R7 pop beyond storage");
    do_pop("R7 pop beyond storage");
    do_pop("R7 pop last slot");

    // R8: wrap
    do_load(8'hFF);
    do_push("R8 wrap up", 8'h5C);
    dcheck("R8 stored at 00", 7'h00);
    do_pop("R8 wrap down");
    do_load(8'h00);
    do_pop("R8 wrap down at 00");

    // R9: write port priority
    do_load(8'h20);
    dir_addr = 7'h50; dir_wr_data = 8'h99; dir_wr_en = 1'b1;
    push_req = 1'b1; stk_wr_data = 8'h12;
    #1;
    check("R9 busy push vs direct", {7'd0, wr_busy}, 8'h01);
    cyc();
    dir_wr_en = 1'b0; push_req = 1'b0;
    exp_sp = 8'h21; exp_mem[8'h21] = 8'h12;
    check("R9 push performed", sp_out, 8'h21);
    dcheck("R9 push data", 7'h21);
    dcheck("R9 direct write blocked", 7'h50);
    bank_sel = 2'd2; reg_num = 3'd3; reg_wr_data = 8'h44; reg_wr_en = 1'b1;
    dir_addr = 7'h51; dir_wr_data = 8'h66; dir_wr_en = 1'b1;
    #1;
    check("R9 busy reg vs direct", {7'd0, wr_busy}, 8'h01);
    cyc();
    reg_wr_en = 1'b0; dir_wr_en = 1'b0; exp_mem[8'h13] = 8'h44;
    dcheck("R9 reg write done", 7'h13);
    dcheck("R9 direct blocked by reg", 7'h51);
    bank_sel = 2'd3; reg_num = 3'd7; reg_wr_data = 8'h3C; reg_wr_en = 1'b1;
    push_req = 1'b1; stk_wr_data = 8'h9E;
    #1;
    check("R9 busy push vs reg", {7'd0, wr_busy}, 8'h01);
    cyc();
    reg_wr_en = 1'b0; push_req = 1'b0;
    exp_sp = 8'h22; exp_mem[8'h22] = 8'h9E;
    dcheck("R9 reg blocked by push", 7'h1F);
    dcheck("R9 push done over reg", 7'h22);
    dir_addr = 7'h52; dir_wr_data = 8'h5D; dir_wr_en = 1'b1;
    #1;
    check("R9 lone direct not busy", {7'd0, wr_busy}, 8'h00);
    cyc();
    dir_wr_en = 1'b0; exp_mem[8'h52] = 8'h5D;
    dcheck("R9 lone direct done", 7'h52);

    // R10: read-before-write
    bank_sel = 2'd1; reg_num = 3'd5; reg_wr_data = 8'hEE; reg_wr_en = 1'b1;
    cyc();
    reg_wr_en = 1'b0;
    check("R10 register old data", reg_rd_data, exp_mem[8'h0D]);
    exp_mem[8'h0D] = 8'hEE;
    cyc();
    check("R10 register new data", reg_rd_data, 8'hEE);
    dir_addr = 7'h33; dir_wr_data = 8'h71; dir_wr_en = 1'b1;
    cyc();
    dir_wr_en = 1'b0;
    check("R10 direct old data", dir_rd_data, exp_mem[8'h33]);
    exp_mem[8'h33] = 8'h71;
    dcheck("R10 direct new data", 7'h33);

    // R11: push and pop together
    push_req = 1'b1; pop_req = 1'b1; stk_wr_data = 8'h6B;
    cyc();
    push_req = 1'b0; pop_req = 1'b0;
    exp_sp = 8'h23; exp_mem[8'h23] = 8'h6B;
    check("R11 only push moves sp", sp_out, 8'h23);
    check("R11 pop_data unchanged", pop_data, last_pop);
    dcheck("R11 push stored", 7'h23);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule